// File: doc/BRIEF.md
# Repeating Loop Code Generator

This block sends a short programmable bit pattern over and over on a serial line. Other logic uses it to send in-band loopback requests to far-end equipment on a T1/E1-style line. Software programs two code bytes (`code_hi`, `code_lo`) and a 2-bit length selector, then sets `tx_enable`. While `tx_enable` is high, the block sends one pattern bit, MSB-first, for each cycle in which the bit-rate enable `bit_en` is high. Each such bit is marked by a one-cycle `ser_valid` pulse. When `tx_enable` is low, the line rests at all-ones.

A small state machine with the states IDLE, LOAD and SEND controls the sequencing:

- IDLE to LOAD happens when `tx_enable` rises.
- LOAD to SEND is unconditional after one cycle. During that cycle the configuration snapshot is taken and the bit pointer is cleared.
- SEND to LOAD happens when a configuration field that the current length uses differs from the snapshot. This restarts the pattern.
- LOAD or SEND to IDLE happens whenever `tx_enable` is low.

The 16-bit length is a full code cycle, so it also produces any pattern whose length divides 16 (1, 2, 4 or 8 bits), provided both bytes are filled with that pattern. The short lengths take their bits from `code_hi` alone.

Top module: `loopcode_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until a bit is sent, `ser_out` is 1 and `ser_valid` is 0.
- R2: In any cycle after an edge at which `tx_enable` is sampled low, `ser_out` is 1 and `ser_valid` is 0, whatever `bit_en` does.
- R3: `len_sel` = 2'b00 selects a 5-bit pattern `code_hi[7:3]`, sent bit 7 first and repeated.
- R4: `len_sel` = 2'b01 selects a 6-bit pattern `code_hi[7:2]`, sent bit 7 first and repeated. Filling it with a 3-bit code twice gives a 3-bit loop code.
- R5: `len_sel` = 2'b10 selects a 7-bit pattern `code_hi[7:1]`, sent bit 7 first and repeated.
- R6: `len_sel` = 2'b11 selects a 16-bit pattern: `code_hi[7:0]` then `code_lo[7:0]`, each MSB-first. It restarts at `code_hi[7]` after `code_lo[0]`. Filling both bytes with a repeated 1-, 2-, 4- or 8-bit code gives that code.
- R7: Exactly one bit is sent per cycle with `bit_en` high while sending. `ser_valid` is high in the cycle after such a `bit_en`, and only then. Between bits, `ser_out` holds its value.
- R8: After `tx_enable` rises (including re-enable in the middle of a pattern), the first bit sent is `code_hi[7]`.
- R9: Changing `code_hi`, or `len_sel`, or `code_lo` in the 16-bit length, while sending restarts the pattern from `code_hi[7]` of the new configuration. No bit is sent in the cycle where the change is seen.
- R10: With a length of 5, 6 or 7 bits, changes to `code_lo` have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable, one pulse per line bit |
| tx_enable | input | 1 | Loop code transmit enable |
| code_hi | input | 8 | First code byte (pattern bits 15:8) |
| code_lo | input | 8 | Second code byte (pattern bits 7:0, 16-bit length only) |
| len_sel | input | 2 | Length select: 00=5, 01=6, 10=7, 11=16 bits |
| ser_out | output | 1 | Serial pattern bit, 1 when idle |
| ser_valid | output | 1 | One-cycle strobe for each bit sent |

## Verification
Each length is tried with patterns whose expected 16-bit streams all differ:

- For the 5-bit length, 80h gives the classic one-in-five code. 08h with an all-ones second byte shows that the second byte is ignored.
- For the 6-bit length, 90h gives a 3-bit code repeated.
- For the 7-bit length, B4h catches wrong cut-off points.
- For the 16-bit length, A5h/3Ch gives a byte-order-sensitive word, and AAh/AAh gives a divisor-length code.

Directed cases cover the following:

- re-enable in the middle of a pattern;
- a change to the first byte while sending, and a second-byte change that must be ignored;
- a gapped `bit_en`, which must not alter the sequence.

// File: rtl/loopcode_pkg.sv
package loopcode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEND = 2'd2
    } lc_state_e;

    localparam logic [1:0] SEL_LEN_A = 2'b00;
    localparam logic [1:0] SEL_LEN_B = 2'b01;
    localparam logic [1:0] SEL_LEN_C = 2'b10;
    localparam logic [1:0] SEL_FULL  = 2'b11;

endpackage

// File: rtl/loopcode_cfg.sv
// Configuration snapshot and restart detector.
module loopcode_cfg #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track,
    input  logic [BYTE_W-1:0] code_hi,
    input  logic [BYTE_W-1:0] code_lo,
    input  logic [SEL_W-1:0]  len_sel,
    output logic [BYTE_W-1:0] snap_hi,
    output logic [BYTE_W-1:0] snap_lo,
    output logic [SEL_W-1:0]  snap_sel,
    output logic              cfg_changed
);
    import loopcode_pkg::*;

    logic hi_diff;
    logic lo_diff;
    logic sel_diff;
    logic lo_used;

    // Follow the live inputs whenever the pattern is not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi  <= '0;
            snap_lo  <= '0;
            snap_sel <= '0;
        end else if (track) begin
            snap_hi  <= code_hi;
            snap_lo  <= code_lo;
            snap_sel <= len_sel;
        end
    end

    // Only fields the active length reads can force a restart.
    always_comb begin
        hi_diff     = (code_hi != snap_hi);
        lo_diff     = (code_lo != snap_lo);
        sel_diff    = (len_sel != snap_sel);
        lo_used     = (snap_sel == SEL_W'(SEL_FULL));
        cfg_changed = hi_diff || sel_diff || (lo_used && lo_diff);
    end

endmodule

// File: rtl/loopcode_fsm.sv
// Control state machine: IDLE -> LOAD -> SEND, with restart and stop arcs.
module loopcode_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_enable,
    input  logic                    cfg_changed,
    output loopcode_pkg::lc_state_e state_q,
    output loopcode_pkg::lc_state_e state_d
);
    import loopcode_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_enable) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (!tx_enable) state_d = ST_IDLE;
                else            state_d = ST_SEND;
            end
            ST_SEND: begin
                if (!tx_enable)       state_d = ST_IDLE;
                else if (cfg_changed) state_d = ST_LOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/loopcode_ptr.sv
// Bit pointer with a wrap point chosen by the length selector.
module loopcode_ptr #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2,
    parameter int LEN_A  = 5,
    parameter int LEN_B  = 6,
    parameter int LEN_C  = 7,
    localparam int FULL_LEN = 2 * BYTE_W,
    localparam int PTR_W    = $clog2(FULL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic [PTR_W-1:0] ptr
);
    import loopcode_pkg::*;

    logic [PTR_W-1:0] last_idx;

    always_comb begin
        unique case (sel)
            SEL_W'(SEL_LEN_A): last_idx = PTR_W'(LEN_A - 1);
            SEL_W'(SEL_LEN_B): last_idx = PTR_W'(LEN_B - 1);
            SEL_W'(SEL_LEN_C): last_idx = PTR_W'(LEN_C - 1);
            default:           last_idx = PTR_W'(FULL_LEN - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (step) begin
            if (ptr == last_idx) ptr <= '0;
            else                 ptr <= ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/loopcode_bitsel.sv
// Picks the current pattern bit, counting from the MSB of the first byte.
module loopcode_bitsel #(
    parameter int BYTE_W = 8,
    localparam int FULL_LEN = 2 * BYTE_W,
    localparam int PTR_W    = $clog2(FULL_LEN)
) (
    input  logic [BYTE_W-1:0] pat_hi,
    input  logic [BYTE_W-1:0] pat_lo,
    input  logic [PTR_W-1:0]  ptr,
    output logic              bit_o
);
    logic [FULL_LEN-1:0] word;
    logic [PTR_W-1:0]    idx;

    always_comb begin
        word  = {pat_hi, pat_lo};
        idx   = PTR_W'(FULL_LEN - 1) - ptr;
        bit_o = word[idx];
    end

endmodule

// File: rtl/loopcode_tx.sv
// Repeating loop code generator, top level.
module loopcode_tx #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2,
    parameter int LEN_A  = 5,
    parameter int LEN_B  = 6,
    parameter int LEN_C  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_enable,
    input  logic [BYTE_W-1:0] code_hi,
    input  logic [BYTE_W-1:0] code_lo,
    input  logic [SEL_W-1:0]  len_sel,
    output logic              ser_out,
    output logic              ser_valid
);
    import loopcode_pkg::*;

    localparam int FULL_LEN = 2 * BYTE_W;
    localparam int PTR_W    = $clog2(FULL_LEN);

    lc_state_e         state_q;
    lc_state_e         state_d;
    logic [BYTE_W-1:0] snap_hi;
    logic [BYTE_W-1:0] snap_lo;
    logic [SEL_W-1:0]  snap_sel;
    logic              cfg_changed;
    logic [PTR_W-1:0]  ptr;
    logic              pat_bit;
    logic              sending;
    logic              take_bit;

    // A bit leaves only from SEND, with enable held and an unchanged setup.
    always_comb begin
        sending  = (state_q == ST_SEND);
        take_bit = sending && tx_enable && !cfg_changed && bit_en;
    end

    loopcode_cfg #(
        .BYTE_W (BYTE_W),
        .SEL_W  (SEL_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .track       (!sending),
        .code_hi     (code_hi),
        .code_lo     (code_lo),
        .len_sel     (len_sel),
        .snap_hi     (snap_hi),
        .snap_lo     (snap_lo),
        .snap_sel    (snap_sel),
        .cfg_changed (cfg_changed)
    );

    loopcode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .cfg_changed (cfg_changed),
        .state_q     (state_q),
        .state_d     (state_d)
    );

    loopcode_ptr #(
        .BYTE_W (BYTE_W),
        .SEL_W  (SEL_W),
        .LEN_A  (LEN_A),
        .LEN_B  (LEN_B),
        .LEN_C  (LEN_C)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!sending),
        .step  (take_bit),
        .sel   (snap_sel),
        .ptr   (ptr)
    );

    loopcode_bitsel #(
        .BYTE_W (BYTE_W)
    ) u_bitsel (
        .pat_hi (snap_hi),
        .pat_lo (snap_lo),
        .ptr    (ptr),
        .bit_o  (pat_bit)
    );

    // Output process: idle marks in IDLE or on stop, bits in SEND.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out   <= 1'b1;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    ser_out <= 1'b1;
                end
                ST_LOAD: begin
                    if (!tx_enable) ser_out <= 1'b1;
                end
                ST_SEND: begin
                    if (!tx_enable) begin
                        ser_out <= 1'b1;
                    end else if (take_bit) begin
                        ser_out   <= pat_bit;
                        ser_valid <= 1'b1;
                    end
                end
                default: begin
                    ser_out <= 1'b1;
                end
            endcase
        end
    end

    // state_d is exported for the checker and kept for observability.
    logic unused_next;
    assign unused_next = ^state_d;

endmodule

// File: rtl/loopcode_tx_chk.sv
// Property checker for loopcode_tx, attached by bind.
module loopcode_tx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              tx_enable,
    input logic [BYTE_W-1:0] code_hi,
    input logic              ser_out,
    input logic              ser_valid
);
    logic first_pending;

    always_ff @(posedge clk) begin
        if (!rst_n)          first_pending <= 1'b1;
        else if (!tx_enable) first_pending <= 1'b1;
        else if (ser_valid)  first_pending <= 1'b0;
    end

    // R1: reset leaves the line idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ser_out && !ser_valid));

    // R2: stop forces idle marks
    a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (ser_out && !ser_valid));

    // R7: a strobe only follows a bit enable
    a_r7_valid_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(bit_en) && $past(tx_enable));

    // R7: line holds between bits
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && !bit_en) |=> ($stable(ser_out) && !ser_valid));

    // R8: first bit after an enable is the first-byte MSB
    a_r8_first_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && first_pending) |-> (ser_out == $past(code_hi[BYTE_W-1])));

endmodule

bind loopcode_tx loopcode_tx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .tx_enable (tx_enable),
    .code_hi   (code_hi),
    .ser_out   (ser_out),
    .ser_valid (ser_valid)
);

// File: tb/loopcode_tx_tb.sv
`timescale 1ns/1ps
module loopcode_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       tx_enable;
    logic [7:0] code_hi;
    logic [7:0] code_lo;
    logic [1:0] len_sel;
    logic       ser_out;
    logic       ser_valid;

    int n_chk = 0;
    int n_bad = 0;
    int gap   = 0;
    int cyc   = 0;
    int b2b   = 0;

    always #2.5 clk = ~clk;

    loopcode_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .tx_enable (tx_enable),
        .code_hi   (code_hi),
        .code_lo   (code_lo),
        .len_sel   (len_sel),
        .ser_out   (ser_out),
        .ser_valid (ser_valid)
    );

    // Bit-rate enable: every cycle, or one in `gap` cycles.
    always @(negedge clk) begin
        cyc++;
        bit_en <= (gap <= 1) ? 1'b1 : ((cyc % gap) == 0);
    end

    // {len_sel, code_hi, code_lo, first 16 bits expected}
    localparam logic [33:0] VEC [0:6] = '{
        {2'b00, 8'h80, 8'h00, 16'h8421},
        {2'b00, 8'h08, 8'hFF, 16'h0842},
        {2'b01, 8'h90, 8'h00, 16'h9249},
        {2'b01, 8'h34, 8'h5A, 16'h34D3},
        {2'b10, 8'hB4, 8'h00, 16'hB56A},
        {2'b11, 8'hA5, 8'h3C, 16'hA53C},
        {2'b11, 8'hAA, 8'hAA, 16'hAAAA}
    };

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic grab(input int n, output logic [15:0] got);
        int k = 0;
        int t = 0;
        logic prev = 1'b0;
        got = '0;
        while (k < n && t < 4000) begin
            @(negedge clk);
            t++;
            if (ser_valid) begin
                if (prev) b2b++;
                got = {got[14:0], ser_out};
                k++;
            end
            prev = ser_valid;
        end
        if (t >= 4000) check("timeout", 32'(k), 32'(n));
    endtask

    task automatic stop_tx();
        @(negedge clk);
        tx_enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_tx(input logic [1:0] s, input logic [7:0] h, input logic [7:0] l);
        len_sel   = s;
        code_hi   = h;
        code_lo   = l;
        tx_enable = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] got;
        int idle_err;
        rst_n = 1'b0; tx_enable = 1'b0; code_hi = '0; code_lo = '0; len_sel = '0;
        repeat (3) @(negedge clk);
        check("R1 reset ser_out", 32'(ser_out), 32'd1);
        check("R1 reset ser_valid", 32'(ser_valid), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset idle", {30'd0, ser_out, ser_valid}, 32'd2);

        // Table walk: lengths R3, R4, R5, R6 (also R8: stream begins at MSB)
        for (int i = 0; i < 7; i++) begin
            string tag;
            case (VEC[i][33:32])
                2'b00:   tag = "R3";
                2'b01:   tag = "R4";
                2'b10:   tag = "R5";
                default: tag = "R6";
            endcase
            stop_tx();
            start_tx(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16]);
            grab(16, got);
            check($sformatf("%s vector %0d", tag, i), 32'(got), 32'(VEC[i][15:0]));
        end

        // R2: idle marks while disabled, bit_en toggling
        stop_tx();
        gap = 2;
        idle_err = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (!(ser_out === 1'b1 && ser_valid === 1'b0)) idle_err++;
        end
        check("R2 idle while disabled", 32'(idle_err), 32'd0);
        gap = 0;

        // R8: re-enable mid-pattern restarts at MSB
        start_tx(2'b00, 8'h80, 8'h00);
        grab(3, got);
        check("R8 partial stream", 32'(got[2:0]), 32'(3'b100));
        stop_tx();
        check("R2 idle after stop", {30'd0, ser_out, ser_valid}, 32'd2);
        start_tx(2'b00, 8'h80, 8'h00);
        grab(16, got);
        check("R8 restart at MSB", 32'(got), 32'h8421);

        // R9: first-byte change while sending restarts with new pattern
        stop_tx();
        start_tx(2'b11, 8'hA5, 8'h3C);
        grab(5, got);
        check("R9 before change", 32'(got[4:0]), 32'(5'b10100));
        code_hi = 8'h0F;
        code_lo = 8'hF0;
        grab(16, got);
        check("R9 restart after change", 32'(got), 32'h0FF0);

        // R10: second-byte change ignored in 5-bit length
        stop_tx();
        start_tx(2'b00, 8'h80, 8'h00);
        grab(3, got);
        code_lo = 8'hFF;
        grab(13, got);
        check("R10 stream unbroken", 32'(got[12:0]), 32'h0421);

        // R7: gapped bit_en keeps the sequence, no back-to-back strobes
        stop_tx();
        gap = 3;
        b2b = 0;
        start_tx(2'b11, 8'hA5, 8'h3C);
        grab(16, got);
        check("R7 gapped sequence", 32'(got), 32'hA53C);
        check("R7 one strobe per tick", 32'(b2b), 32'd0);
        gap = 0;
        stop_tx();

        summary();
        $finish;
    end

endmodule